// File: doc/BRIEF.md
# Circular Hardware Return Stack

This block is the on-chip stack of a small processor core. It holds sixteen 16-bit entries for return addresses and for data the program saves. Call, explicit push and interrupt-entry operations share one push strobe. Return, return-from-interrupt and explicit pop operations share one pop strobe. The core sees the stack pointer at all times, and it sees the entry that pointer addresses on a combinational read port.

The pointer moves around a ring. A push advances the pointer first and then writes at the new index. A pop delivers the entry at the current index and then steps the pointer back. Because the pointer starts at the highest index, the first push after reset lands at index 0. Running past either end wraps around silently. Overflow and underflow are left to software.

Top module: `hw_return_stack`

## Requirements
- R1: The stack stores 16 entries of 16 bits each. After sixteen pushes of distinct values, sixteen pops return them in reverse order of pushing.
- R2: A synchronous reset (`rst` high at a rising edge) sets the pointer to 15 at that edge. Stored entries keep their values through reset.
- R3: A push with no pop advances the pointer by one at the clock edge and writes `push_data_i` at the advanced index. The first push after reset therefore goes to index 0 and leaves the pointer at 0.
- R4: `pop_data_o` always shows, combinationally, the entry at the current pointer. A pop delivers that value in the cycle it is asserted and lowers the pointer by one at the clock edge.
- R5: A push while the pointer is 15 wraps the pointer to 0 and writes index 0.
- R6: A pop while the pointer is 0 wraps the pointer to 15. No error is raised.
- R7: When push and pop are both asserted, only the pop takes effect. The push data is written nowhere.
- R8: With neither strobe asserted, the pointer and all entries are unchanged, whatever `push_data_i` carries.
- R9: A push asserted in a cycle with reset high is ignored: no entry is written.

Each requirement states the observable result a bench can check at the ports: index 0 is the first written slot after reset (R3), and pop data is taken before the decrement (R4).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| push_i | input | 1 | Push strobe (call, explicit push, interrupt entry) |
| push_data_i | input | 16 | Value to store on a push |
| pop_i | input | 1 | Pop strobe (return, interrupt return, explicit pop) |
| pop_data_o | output | 16 | Entry at the current pointer |
| sp_o | output | 4 | Current stack pointer |

## Verification
A pointer that steps wrongly shows on `sp_o` at the very next edge. It also shows on `pop_data_o` in the same cycle, because the read port follows the pointer. A write that lands at the wrong index does not show on `sp_o`. It shows only when that index is read back, which can take up to sixteen pops later around the ring. The bench therefore fills the whole ring and unwinds it completely after the collision and reset-with-push cases.

// File: rtl/stk_pkg.sv
package stk_pkg;
  localparam int STK_DATA_W = 16;
  localparam int STK_DEPTH  = 16;

  // Operation chosen for the current cycle
  typedef enum logic [1:0] {
    STK_IDLE = 2'd0,
    STK_PUSH = 2'd1,
    STK_POP  = 2'd2
  } stk_op_e;
endpackage

// File: rtl/stk_ctrl.sv
module stk_ctrl
  import stk_pkg::*;
(
  input  logic    rst,
  input  logic    push_req,
  input  logic    pop_req,
  output stk_op_e op,
  output logic    wr_en,
  output logic    dn_en
);
  // Reset wins over both strobes, and pop wins over push.
  always_comb begin
    if (rst)           op = STK_IDLE;
    else if (pop_req)  op = STK_POP;
    else if (push_req) op = STK_PUSH;
    else               op = STK_IDLE;
  end

  assign wr_en = (op == STK_PUSH);
  assign dn_en = (op == STK_POP);
endmodule

// File: rtl/stk_ptr.sv
module stk_ptr
  import stk_pkg::*;
#(
  parameter int DEPTH = STK_DEPTH,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  stk_op_e          op,
  output logic [PTR_W-1:0] sp,
  output logic [PTR_W-1:0] sp_up
);
  localparam logic [PTR_W-1:0] TOP_IDX = PTR_W'(DEPTH - 1);

  // Ring step forward: the highest index wraps to zero.
  function automatic logic [PTR_W-1:0] ring_up(input logic [PTR_W-1:0] p);
    return (p == TOP_IDX) ? '0 : p + 1'b1;
  endfunction

  // Ring step back: zero wraps to the highest index.
  function automatic logic [PTR_W-1:0] ring_down(input logic [PTR_W-1:0] p);
    return (p == '0) ? TOP_IDX : p - 1'b1;
  endfunction

  assign sp_up = ring_up(sp);

  always_ff @(posedge clk) begin
    if (rst) begin
      sp <= TOP_IDX;
    end else begin
      case (op)
        STK_PUSH: sp <= sp_up;
        STK_POP:  sp <= ring_down(sp);
        default:  sp <= sp;
      endcase
    end
  end

  // R2
  ptr_reset_chk: assert property (@(posedge clk) rst |=> sp == TOP_IDX);
endmodule

// File: rtl/stk_mem.sv
module stk_mem #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 16,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] cells [DEPTH];

  // One register per entry; reset does not touch contents.
  for (genvar e = 0; e < DEPTH; e++) begin : g_cell
    always_ff @(posedge clk) begin
      if (we && (waddr == ADDR_W'(e))) cells[e] <= wdata;
    end
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/hw_return_stack.sv
module hw_return_stack
  import stk_pkg::*;
#(
  parameter int DATA_W = STK_DATA_W,
  parameter int DEPTH  = STK_DEPTH,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push_i,
  input  logic [DATA_W-1:0] push_data_i,
  input  logic              pop_i,
  output logic [DATA_W-1:0] pop_data_o,
  output logic [PTR_W-1:0]  sp_o
);
  localparam logic [PTR_W-1:0] TOP_IDX = PTR_W'(DEPTH - 1);

  // Named internal events for the checks below
  stk_op_e          cur_op;
  logic             push_fire;
  logic             pop_fire;
  logic [PTR_W-1:0] wr_idx;

  stk_ctrl u_ctrl (
    .rst      (rst),
    .push_req (push_i),
    .pop_req  (pop_i),
    .op       (cur_op),
    .wr_en    (push_fire),
    .dn_en    (pop_fire)
  );

  stk_ptr #(.DEPTH(DEPTH)) u_ptr (
    .clk   (clk),
    .rst   (rst),
    .op    (cur_op),
    .sp    (sp_o),
    .sp_up (wr_idx)
  );

  stk_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_mem (
    .clk   (clk),
    .we    (push_fire),
    .waddr (wr_idx),
    .wdata (push_data_i),
    .raddr (sp_o),
    .rdata (pop_data_o)
  );

  // R3
  push_step_chk: assert property (@(posedge clk) disable iff (rst)
    (push_i && !pop_i && sp_o != TOP_IDX) |=> sp_o == $past(sp_o) + 1'b1);
  // R3
  push_lands_chk: assert property (@(posedge clk) disable iff (rst)
    (push_i && !pop_i) |=> pop_data_o == $past(push_data_i));
  // R4
  pop_step_chk: assert property (@(posedge clk) disable iff (rst)
    (pop_i && sp_o != '0) |=> sp_o == $past(sp_o) - 1'b1);
  // R5
  wrap_up_chk: assert property (@(posedge clk) disable iff (rst)
    (push_i && !pop_i && sp_o == TOP_IDX) |=> sp_o == '0);
  // R6
  wrap_down_chk: assert property (@(posedge clk) disable iff (rst)
    (pop_i && sp_o == '0) |=> sp_o == TOP_IDX);
  // R7
  one_op_chk: assert property (@(posedge clk) disable iff (rst)
    !(push_fire && pop_fire));
  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!push_i && !pop_i) |=> ($stable(sp_o) && $stable(pop_data_o)));
  // R9
  rst_blocks_push_chk: assert property (@(posedge clk)
    rst |-> !push_fire);
endmodule

// File: tb/hw_return_stack_test.sv
module hw_return_stack_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        push = 1'b0;
  logic        pop = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [3:0]  sp;

  int n_run = 0;
  int n_fail = 0;
  logic [15:0] mdl [16];
  logic [3:0]  msp = 4'hF;

  always #4 clk = ~clk;

  hw_return_stack uut (
    .clk(clk), .rst(rst), .push_i(push), .push_data_i(wdata),
    .pop_i(pop), .pop_data_o(rdata), .sp_o(sp)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // One cycle of stimulus starting at a falling edge; model kept separately.
  task automatic step(input logic p, input logic q, input logic [15:0] d, input string tag);
    push = p; pop = q; wdata = d;
    #1;
    if (q) chk(tag, {16'h0, rdata}, {16'h0, mdl[msp]});
    if (q) msp = msp - 4'd1;
    else if (p) begin
      msp = msp + 4'd1;
      mdl[msp] = d;
    end
    @(negedge clk);
    push = 1'b0; pop = 1'b0;
    chk(tag, {28'h0, sp}, {28'h0, msp});
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    msp = 4'hF;
    chk("R2", {28'h0, sp}, 32'hF);
  endtask

  function automatic logic [15:0] pat(input int i);
    return 16'h8001 ^ 16'(i * 16'h1357);
  endfunction

  task automatic t_first_push();
    do_reset();
    step(1'b1, 1'b0, 16'hBEEF, "R3");
    chk("R3", {28'h0, sp}, 32'h0);
    chk("R4", {16'h0, rdata}, 32'hBEEF);
    step(1'b0, 1'b1, 16'h0000, "R4");
    chk("R6", {28'h0, sp}, 32'hF);
  endtask

  task automatic t_fill_lifo();
    do_reset();
    for (int i = 0; i < 16; i++) step(1'b1, 1'b0, pat(i), "R1");
    chk("R1", {28'h0, sp}, 32'hF);
    for (int i = 15; i >= 0; i--) begin
      chk("R1", {16'h0, rdata}, {16'h0, pat(i)});
      step(1'b0, 1'b1, 16'h0000, "R1");
    end
  endtask

  task automatic t_wrap_up();
    do_reset();
    for (int i = 0; i < 16; i++) step(1'b1, 1'b0, pat(i + 3), "R5");
    step(1'b1, 1'b0, 16'h5A5A, "R5");
    chk("R5", {28'h0, sp}, 32'h0);
    chk("R5", {16'h0, rdata}, 32'h5A5A);
  endtask

  task automatic t_wrap_down();
    do_reset();
    step(1'b1, 1'b0, 16'h1234, "R6");
    step(1'b0, 1'b1, 16'h0000, "R6");
    chk("R6", {28'h0, sp}, 32'hF);
    step(1'b1, 1'b0, 16'h4321, "R6");
    step(1'b0, 1'b1, 16'h0000, "R6");
    chk("R6", {28'h0, sp}, 32'hF);
  endtask

  task automatic t_collision();
    do_reset();
    for (int i = 0; i < 16; i++) step(1'b1, 1'b0, pat(i + 7), "R7");
    step(1'b1, 1'b1, 16'hDEAD, "R7");
    chk("R7", {28'h0, sp}, 32'hE);
    // Unwind to index 0, where the ignored push would have landed.
    for (int i = 0; i < 15; i++) step(1'b0, 1'b1, 16'h0000, "R7");
    chk("R7", {28'h0, sp}, 32'hF);
  endtask

  task automatic t_idle();
    logic [15:0] top_v;
    do_reset();
    step(1'b1, 1'b0, 16'h0F0F, "R8");
    step(1'b1, 1'b0, 16'hF0F0, "R8");
    top_v = rdata;
    for (int i = 0; i < 5; i++) begin
      wdata = pat(i + 20);
      @(negedge clk);
      chk("R8", {28'h0, sp}, 32'h1);
      chk("R8", {16'h0, rdata}, {16'h0, top_v});
    end
    step(1'b0, 1'b1, 16'h0000, "R8");
    step(1'b0, 1'b1, 16'h0000, "R8");
  endtask

  task automatic t_reset_push();
    do_reset();
    for (int i = 0; i < 16; i++) step(1'b1, 1'b0, pat(i + 11), "R9");
    rst = 1'b1; push = 1'b1; wdata = 16'hBAD0;
    @(negedge clk);
    rst = 1'b0; push = 1'b0;
    msp = 4'hF;
    chk("R2", {28'h0, sp}, 32'hF);
    chk("R2", {16'h0, rdata}, {16'h0, pat(15 + 11)});
    for (int i = 0; i < 16; i++) step(1'b0, 1'b1, 16'h0000, "R9");
  endtask

  initial begin
    #(8 * 200000);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk("R2", {28'h0, sp}, 32'hF);
    t_first_push();
    t_fill_lifo();
    t_wrap_up();
    t_wrap_down();
    t_collision();
    t_idle();
    t_reset_push();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule